// File: doc/BRIEF.md
# Embedded controller host port

This block is the host-side front end of an embedded controller. The host sees two byte-wide I/O locations. One is a data port. The other reads back a status byte and accepts command bytes when written. Behind the two ports sits a 256-entry byte register space. The block reaches that space through a simple synchronous port, and read data returns one cycle after the read strobe.

Every exchange is driven by handshake flags. Before it writes any byte, the host polls the status byte and waits until the input-full flag drops. Before it reads a result, it waits until the output-full flag rises. A sequencer consumes host bytes after a programmable delay. It turns command-plus-operand sequences into register reads and writes. It also handles burst enable and disable, and answers a query with the number of the pending event from a single event source.

Top module: `ec_host_port`

## Requirements
- R1: Only two host offsets are decoded: DATA_PORT (default 0) is the data port, and CTRL_PORT (default 4) returns status on read and takes commands on write. A write to any other offset is ignored and leaves the input-full flag at 0. A read of any other offset returns 0x00.
- R2: The status byte has bit 0 = output full, bit 1 = input full, bit 3 = last host byte was a command, bit 4 = burst active, and bit 5 = event pending (follows evt_valid_i). All other bits read 0, and the byte is 0x00 after reset.
- R3: Any host write to either decoded port sets input full in the next cycle. The flag stays high for exactly CONSUME_DLY cycles when the sequencer is free. Bit 3 is 1 after a write to CTRL_PORT and 0 after a write to DATA_PORT.
- R4: Command 0x80 followed by one address byte reads that register. The value then appears at the data port and output full is set.
- R5: Command 0x81 followed by an address byte and then a data byte performs exactly one register write of that data at that address. The write and read strobes are never both active.
- R6: A host read of the data port clears output full. A read of the status byte leaves it unchanged.
- R7: Command 0x82 sets the burst bit, places 0x90 at the data port and sets output full. Command 0x83 clears the burst bit and does not touch output full.
- R8: Command 0x84 returns evt_code_i and pulses evt_ack_o for one cycle when an event is pending. When no event is pending it returns 0x00 and gives no acknowledge. In both cases output full is set.
- R9: A command byte that arrives in the middle of a sequence abandons that sequence, with no register access, and starts the new command.
- R10: A data byte that arrives with no sequence open, or after an unknown command, is discarded. It causes no register access and does not set output full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | HA_W | Host port offset |
| host_wr_i | input | 1 | Host write strobe, one cycle per byte |
| host_rd_i | input | 1 | Host read strobe, one cycle per byte |
| host_wdata_i | input | DW | Host write byte |
| host_rdata_o | output | DW | Host read byte (combinational from offset) |
| rs_addr_o | output | AW | Register space address |
| rs_wdata_o | output | DW | Register space write data |
| rs_we_o | output | 1 | Register space write enable |
| rs_re_o | output | 1 | Register space read enable; data returns next cycle |
| rs_rdata_i | input | DW | Register space read data |
| evt_valid_i | input | 1 | Event pending from the event source |
| evt_code_i | input | DW | Number of the pending event |
| evt_ack_o | output | 1 | One-cycle acknowledge when a query reports the event |

## Verification
The bench builds the block with CONSUME_DLY set to 3 and HA_W left at 3. The longer consume delay keeps the input-full flag up for a run of cycles that can be counted exactly, so the hold window and the command/data bit can be observed between write and consumption. A three-bit offset leaves six undecoded locations. Writes and reads there show whether the decoder ignores them, while the register model behind the block records every strobe.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;
  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;
  localparam logic [7:0] BURST_ACK    = 8'h90;

  localparam int ST_OUT_FULL = 0;
  localparam int ST_IN_FULL  = 1;
  localparam int ST_IS_CMD   = 3;
  localparam int ST_BURST    = 4;
  localparam int ST_EVT      = 5;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RADDR,
    SQ_RDATA,
    SQ_WADDR,
    SQ_WDATA
  } seq_state_e;
endpackage

// File: rtl/ec_host_inlatch.sv
module ec_host_inlatch #(
  parameter int HA_W        = 3,
  parameter int DW          = 8,
  parameter int DATA_PORT   = 0,
  parameter int CTRL_PORT   = 4,
  parameter int CONSUME_DLY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [HA_W-1:0] host_addr_i,
  input  logic            host_wr_i,
  input  logic [DW-1:0]   host_wdata_i,
  input  logic            accept_i,
  output logic            ready_o,
  output logic [DW-1:0]   byte_o,
  output logic            is_cmd_o,
  output logic            full_o
);
  localparam int CW = $clog2(CONSUME_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(CONSUME_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          hit_data, hit_ctrl, hit;

  assign hit_data = host_addr_i == HA_W'(DATA_PORT);
  assign hit_ctrl = host_addr_i == HA_W'(CTRL_PORT);
  assign hit      = host_wr_i && (hit_data || hit_ctrl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o   <= '0;
      is_cmd_o <= 1'b0;
      full_o   <= 1'b0;
      cnt_q    <= '0;
    end else if (hit) begin
      // a newer byte replaces one not yet consumed
      byte_o   <= host_wdata_i;
      is_cmd_o <= hit_ctrl;
      full_o   <= 1'b1;
      cnt_q    <= '0;
    end else if (accept_i) begin
      full_o   <= 1'b0;
    end else if (full_o && cnt_q != LAST) begin
      cnt_q    <= cnt_q + CW'(1);
    end
  end

  assign ready_o = full_o && (cnt_q == LAST) && !hit;
endmodule

// File: rtl/ec_host_seq.sv
module ec_host_seq
  import ec_host_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic [DW-1:0] byte_i,
  input  logic          is_cmd_i,
  input  logic [DW-1:0] rs_rdata_i,
  input  logic          evt_valid_i,
  input  logic [DW-1:0] evt_code_i,
  output logic          accept_o,
  output logic [AW-1:0] rs_addr_o,
  output logic [DW-1:0] rs_wdata_o,
  output logic          rs_we_o,
  output logic          rs_re_o,
  output logic          load_o,
  output logic [DW-1:0] load_data_o,
  output logic          burst_o,
  output logic          evt_ack_o
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          burst_d;

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    burst_d     = burst_o;
    accept_o    = ready_i && (state_q != SQ_RDATA);
    rs_addr_o   = addr_q;
    rs_wdata_o  = byte_i;
    rs_we_o     = 1'b0;
    rs_re_o     = 1'b0;
    load_o      = 1'b0;
    load_data_o = rs_rdata_i;
    evt_ack_o   = 1'b0;

    if (state_q == SQ_RDATA) begin
      load_o  = 1'b1;
      state_d = SQ_IDLE;
    end

    if (accept_o) begin
      if (is_cmd_i) begin
        // any command closes the open sequence
        state_d = SQ_IDLE;
        unique case (byte_i[7:0])
          OP_READ:      state_d = SQ_RADDR;
          OP_WRITE:     state_d = SQ_WADDR;
          OP_BURST_ON: begin
            burst_d     = 1'b1;
            load_o      = 1'b1;
            load_data_o = DW'(BURST_ACK);
          end
          OP_BURST_OFF: burst_d = 1'b0;
          OP_QUERY: begin
            load_o      = 1'b1;
            load_data_o = evt_valid_i ? evt_code_i : '0;
            evt_ack_o   = evt_valid_i;
          end
          default: ;
        endcase
      end else begin
        unique case (state_q)
          SQ_RADDR: begin
            rs_re_o   = 1'b1;
            rs_addr_o = AW'(byte_i);
            state_d   = SQ_RDATA;
          end
          SQ_WADDR: begin
            addr_d  = AW'(byte_i);
            state_d = SQ_WDATA;
          end
          SQ_WDATA: begin
            rs_we_o = 1'b1;
            state_d = SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      burst_o <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      burst_o <= burst_d;
    end
  end
endmodule

// File: rtl/ec_host_outbuf.sv
module ec_host_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          clr_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      // a fresh result wins over a simultaneous host read
      full_o <= 1'b1;
      data_o <= load_data_i;
    end else if (clr_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_host_pkg::*;
#(
  parameter int HA_W        = 3,
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int DATA_PORT   = 0,
  parameter int CTRL_PORT   = 4,
  parameter int CONSUME_DLY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [HA_W-1:0] host_addr_i,
  input  logic            host_wr_i,
  input  logic            host_rd_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [DW-1:0]   host_rdata_o,
  output logic [AW-1:0]   rs_addr_o,
  output logic [DW-1:0]   rs_wdata_o,
  output logic            rs_we_o,
  output logic            rs_re_o,
  input  logic [DW-1:0]   rs_rdata_i,
  input  logic            evt_valid_i,
  input  logic [DW-1:0]   evt_code_i,
  output logic            evt_ack_o
);
  logic          in_full, in_ready, in_is_cmd, accept;
  logic [DW-1:0] in_byte;
  logic          out_full, ld_valid, burst;
  logic [DW-1:0] out_data, ld_data, status;

  ec_host_inlatch #(
    .HA_W(HA_W), .DW(DW), .DATA_PORT(DATA_PORT),
    .CTRL_PORT(CTRL_PORT), .CONSUME_DLY(CONSUME_DLY)
  ) u_inlatch (
    .clk_i, .rst_ni, .host_addr_i, .host_wr_i, .host_wdata_i,
    .accept_i (accept),
    .ready_o  (in_ready),
    .byte_o   (in_byte),
    .is_cmd_o (in_is_cmd),
    .full_o   (in_full)
  );

  ec_host_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni,
    .ready_i     (in_ready),
    .byte_i      (in_byte),
    .is_cmd_i    (in_is_cmd),
    .rs_rdata_i, .evt_valid_i, .evt_code_i,
    .accept_o    (accept),
    .rs_addr_o, .rs_wdata_o, .rs_we_o, .rs_re_o,
    .load_o      (ld_valid),
    .load_data_o (ld_data),
    .burst_o     (burst),
    .evt_ack_o
  );

  ec_host_outbuf #(.DW(DW)) u_outbuf (
    .clk_i, .rst_ni,
    .load_i      (ld_valid),
    .load_data_i (ld_data),
    .clr_i       (host_rd_i && host_addr_i == HA_W'(DATA_PORT)),
    .full_o      (out_full),
    .data_o      (out_data)
  );

  always_comb begin
    status              = '0;
    status[ST_OUT_FULL] = out_full;
    status[ST_IN_FULL]  = in_full;
    status[ST_IS_CMD]   = in_is_cmd;
    status[ST_BURST]    = burst;
    status[ST_EVT]      = evt_valid_i;
  end

  always_comb begin
    if (host_addr_i == HA_W'(DATA_PORT))      host_rdata_o = out_data;
    else if (host_addr_i == HA_W'(CTRL_PORT)) host_rdata_o = status;
    else                                      host_rdata_o = '0;
  end
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
  parameter int HA_W        = 3,
  parameter int DATA_PORT   = 0,
  parameter int CTRL_PORT   = 4,
  parameter int CONSUME_DLY = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [HA_W-1:0] host_addr_i,
  input logic            host_wr_i,
  input logic            host_rd_i,
  input logic            in_full,
  input logic            out_full,
  input logic            ld_valid,
  input logic            rs_we_o,
  input logic            rs_re_o,
  input logic            evt_valid_i,
  input logic            evt_ack_o
);
  logic at_data, at_ctrl;
  assign at_data = host_addr_i == HA_W'(DATA_PORT);
  assign at_ctrl = host_addr_i == HA_W'(CTRL_PORT);

  a_r3_write_sets_in_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && (at_data || at_ctrl) |=> in_full);

  a_r1_stray_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !at_data && !at_ctrl && !in_full |=> !in_full);

  a_r5_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rs_we_o && rs_re_o));

  a_r4_read_fills_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_re_o |=> ##1 out_full);

  a_r6_data_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && at_data && !ld_valid |=> !out_full);

  a_r8_ack_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ack_o |-> evt_valid_i);

  if (CONSUME_DLY > 1) begin : g_hold
    a_r3_in_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(in_full) |=> in_full);
  end
endmodule

bind ec_host_port ec_host_port_chk #(
  .HA_W(HA_W), .DATA_PORT(DATA_PORT), .CTRL_PORT(CTRL_PORT), .CONSUME_DLY(CONSUME_DLY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_addr_i(host_addr_i), .host_wr_i(host_wr_i),
  .host_rd_i(host_rd_i), .in_full(in_full), .out_full(out_full), .ld_valid(ld_valid),
  .rs_we_o(rs_we_o), .rs_re_o(rs_re_o), .evt_valid_i(evt_valid_i), .evt_ack_o(evt_ack_o)
);

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA_W = 3;
  localparam int DLY  = 3;
  localparam int NV   = 11;
  // {is_read, address, data}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'hA5}, {1'b0, 8'hFE, 8'h3C}, {1'b0, 8'h80, 8'h00},
    {1'b0, 8'h00, 8'hFF}, {1'b1, 8'h01, 8'hA5}, {1'b1, 8'hFE, 8'h3C},
    {1'b1, 8'h80, 8'h00}, {1'b1, 8'h00, 8'hFF}, {1'b1, 8'h33, 8'h69},
    {1'b0, 8'h33, 8'h12}, {1'b1, 8'h33, 8'h12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HA_W-1:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, rs_addr, rs_wdata, rs_rdata, evt_code;
  logic rs_we, rs_re, evt_ack, evt_valid, evt_raise = 1'b0;
  logic [7:0] mem [256];
  int wr_cnt, re_cnt, ack_cnt, checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ec_host_port #(.HA_W(HA_W), .CONSUME_DLY(DLY)) u_ec_host_port (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(host_addr), .host_wr_i(host_wr),
    .host_rd_i(host_rd), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .rs_addr_o(rs_addr), .rs_wdata_o(rs_wdata), .rs_we_o(rs_we), .rs_re_o(rs_re),
    .rs_rdata_i(rs_rdata), .evt_valid_i(evt_valid), .evt_code_i(evt_code),
    .evt_ack_o(evt_ack)
  );

  assign evt_code = 8'h3C;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      rs_rdata <= '0; wr_cnt <= 0; re_cnt <= 0; ack_cnt <= 0; evt_valid <= 1'b0;
    end else begin
      if (rs_we) begin mem[rs_addr] <= rs_wdata; wr_cnt <= wr_cnt + 1; end
      if (rs_re) begin rs_rdata <= mem[rs_addr]; re_cnt <= re_cnt + 1; end
      if (evt_raise) evt_valid <= 1'b1;
      else if (evt_ack) begin evt_valid <= 1'b0; ack_cnt <= ack_cnt + 1; end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [HA_W-1:0] a, output logic [7:0] v);
    host_addr = a; #1 v = host_rdata;
  endtask

  task automatic wait_flag(input int bitn, input logic lvl);
    logic [7:0] s;
    bit ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); peek(3'd4, s);
      if (s[bitn] == lvl) begin ok = 1; break; end
    end
    if (!ok) check("handshake timeout", 0, 1);
  endtask

  task automatic host_write(input logic [HA_W-1:0] a, input logic [7:0] d);
    wait_flag(1, 1'b0);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); host_addr = '0; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic ec_read(input logic [7:0] a, output logic [7:0] v);
    host_write(3'd4, 8'h80); host_write(3'd0, a);
    wait_flag(0, 1'b1); rd_data(v);
  endtask

  task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
    host_write(3'd4, 8'h81); host_write(3'd0, a); host_write(3'd0, d);
    wait_flag(1, 1'b0);
  endtask

  initial begin
    logic [7:0] v, s;
    int n, w0, r0, a0;
    repeat (3) @(negedge clk);
    // R2: reset value of status and no register strobes
    peek(3'd4, s); check("R2 reset status", s, 8'h00);
    peek(3'd0, v); check("R2 reset data port", v, 8'h00);
    check("R5 no write strobe in reset", rs_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][16]) begin
        ec_read(VEC[k][15:8], v);
        check("R4 table read", v, VEC[k][7:0]);
      end else begin
        ec_write(VEC[k][15:8], VEC[k][7:0]);
      end
    end
    check("R5 one strobe per write", wr_cnt, 5);

    // R3: input-full hold window and command bit
    host_write(3'd4, 8'h83);
    n = 0;
    peek(3'd4, s);
    check("R3 bit3 after command", s[3], 1);
    while (s[1] && n < 50) begin n++; @(negedge clk); peek(3'd4, s); end
    check("R3 in_full hold cycles", n, DLY);
    host_write(3'd0, 8'h11);
    peek(3'd4, s); check("R3 bit3 after data", s[3], 0);
    wait_flag(1, 1'b0);

    // R1: stray offsets
    w0 = wr_cnt;
    @(negedge clk); host_addr = 3'd2; host_wdata = 8'h80; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    peek(3'd4, s); check("R1 stray write leaves in_full low", s[1], 0);
    peek(3'd6, v); check("R1 stray read is zero", v, 8'h00);

    // R7 / R6: burst on, status read keeps out_full, data read clears it
    host_write(3'd4, 8'h82); wait_flag(0, 1'b1);
    peek(3'd4, s); check("R7 burst bit set", s[4], 1);
    @(negedge clk); host_rd = 1'b1; peek(3'd4, s);
    @(negedge clk); host_rd = 1'b0; peek(3'd4, s);
    check("R6 status read keeps out_full", s[0], 1);
    rd_data(v); check("R7 burst ack byte", v, 8'h90);
    peek(3'd4, s); check("R6 data read clears out_full", s[0], 0);
    host_write(3'd4, 8'h83); wait_flag(1, 1'b0);
    @(negedge clk); peek(3'd4, s);
    check("R7 burst off, out_full untouched", s & 8'h11, 8'h00);

    // R8: query without and with a pending event
    a0 = ack_cnt;
    host_write(3'd4, 8'h84); wait_flag(0, 1'b1); rd_data(v);
    check("R8 empty query byte", v, 8'h00);
    check("R8 no ack when empty", ack_cnt, a0);
    @(negedge clk); evt_raise = 1'b1; @(negedge clk); evt_raise = 1'b0;
    peek(3'd4, s); check("R2 event bit", s[5], 1);
    host_write(3'd4, 8'h84); wait_flag(0, 1'b1); rd_data(v);
    check("R8 query returns event", v, 8'h3C);
    check("R8 one ack", ack_cnt, a0 + 1);
    peek(3'd4, s); check("R8 event bit cleared", s[5], 0);

    // R9: write abandoned by a read command
    w0 = wr_cnt;
    host_write(3'd4, 8'h81); host_write(3'd0, 8'h10);
    ec_read(8'h10, v);
    check("R9 aborted write leaves data", v, 8'h4A);
    check("R9 no write strobe", wr_cnt, w0);

    // R10: orphan data and unknown command
    w0 = wr_cnt; r0 = re_cnt;
    host_write(3'd0, 8'h77);
    host_write(3'd4, 8'h85); host_write(3'd0, 8'h05); host_write(3'd0, 8'h06);
    wait_flag(1, 1'b0); repeat (3) @(negedge clk);
    peek(3'd4, s);
    check("R10 no out_full", s[0], 0);
    check("R10 no write", wr_cnt, w0);
    check("R10 no read", re_cnt, r0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule